// File: doc/BRIEF.md
# Clock Gating and Sleep-Wake Controller

This block runs from one reference oscillator that never stops. From it the block makes two clock-enable outputs. The first is a host-processor clock enable whose rate a register selects. The second is a signal-processor clock enable that follows a sleep/wake sequence. The host-processor clock is a stream of enable pulses at reference/1, /2 or /4. Rate and gating changes are taken up only at the end of a full four-cycle divider period, so no shortened pulse pattern appears.

The signal processor puts itself to sleep by writing a clock-stop command. Its clock enable then drops, and the lock-delay counter that models the PLL is held. Either of two events wakes it:

- a host mailbox message strobe;
- a timer strobe.

Wake-up is a strict two-step sequence. The clock enable returns at once. After a programmable settling count, a one-cycle interrupt pulse goes out on one of two lines. The signal processor reset output is never touched by this sequence, so the processor resumes where it stopped. A wake event while the clock is already running or settling is dropped.

Top module: `clkslp_top`

## Requirements
- R1: After reset the block is in this state:
  - host rate code is 1 (reference/2) and the host clock is enabled;
  - `dspClkEn`=1 and `pllLocked`=1;
  - `wakeInt`=0;
  - the settling count is 256 and the interrupt line select is 0.
- R2: A host write to address 0 selects the host clock rate with bits [1:0]. Code 0 gives reference/1, code 1 gives reference/2 and code 2 gives reference/4. `hostClkEn` then pulses once every 1, 2 or 4 reference cycles. A write of code 3 is ignored and the previous rate stays.
- R3: A new rate or host enable takes effect only at the end of a four-cycle divider period. At reference/4 successive `hostClkEn` pulses are exactly 4 cycles apart.
- R4: A host write to address 1 bit 0 enables (1) or gates off (0) the host clock. While it is off `hostClkEn` stays 0.
- R5: Register ownership is split by source:
  - writes to addresses 0 and 1 are accepted only with `regFromDsp`=0;
  - writes to address 2 are accepted only with `regFromDsp`=1;
  - a write from the wrong source has no effect.
- R6: A signal-processor write of bit 0 = 1 to address 2 while running puts the signal processor to sleep. In the next cycle `dspClkEn`=0, `pllLocked`=0 and `dspAsleep`=1.
- R7: While asleep, a `mailboxMsg` or `timerWake` strobe sets `dspClkEn`=1 in the next cycle. `pllLocked` stays 0 until the interrupt pulse.
- R8: The interrupt pulse is exactly one cycle long. It appears D cycles after `dspClkEn` returns, where D is the 16-bit settling count written at address 3 (D=0 behaves as D=1). `pllLocked` goes to 1 with the pulse.
- R9: The interrupt line comes from address 4 bit 0, sampled at the wake event. Value 0 pulses `wakeInt[0]` and value 1 pulses `wakeInt[1]`.
- R10: A wake strobe while the signal processor clock is running or settling is ignored. It produces no interrupt and does not restart the settling count.
- R11: `dspRstN` is 0 only while `rstN` is asserted. It stays 1 through sleep, wake and settling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regFromDsp | input | 1 | Write source: 1 signal processor, 0 host |
| regAddr | input | 3 | Register address |
| regWdata | input | 16 | Register write data |
| mailboxMsg | input | 1 | Host mailbox message strobe (wake source) |
| timerWake | input | 1 | Wake timer strobe (wake source) |
| hostClkEn | output | 1 | Host clock enable pulse at the selected rate |
| dspClkEn | output | 1 | Signal processor clock enable |
| pllLocked | output | 1 | Lock-delay model has settled |
| wakeInt | output | 2 | One-cycle wake interrupt, one bit per line |
| dspRstN | output | 1 | Signal processor reset, active low |
| dspAsleep | output | 1 | Status: signal processor clock stopped |

## Verification
Assertions in the RTL check the following on every cycle:
- host rate and enable changes happen only at a divider wrap;
- at most one interrupt line is high;
- an interrupt never shares a cycle with a clock restart;
- the reset output is high whenever the clock restarts;
- the clock stops only on an accepted sleep command;
- a wake while running leaves the controller running.

Only the bench scenarios show the following:
- the exact settling distance for several counts, including the 0 and 1 corner;
- the choice of interrupt line;
- the pulse rates counted over a window;
- that writes from the wrong source and wakes at the wrong time leave no trace at the ports.

// File: rtl/clkslp_pkg.sv
package clkslp_pkg;
  localparam int ADDR_W = 3;
  localparam int DIV_W  = 2;

  localparam logic [ADDR_W-1:0] ADDR_RATE   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_HOSTEN = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_DSPCMD = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_DELAY  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_INTSEL = 3'd4;

  localparam logic [1:0] RATE_DIV1 = 2'd0;
  localparam logic [1:0] RATE_DIV2 = 2'd1;
  localparam logic [1:0] RATE_DIV4 = 2'd2;
  localparam logic [1:0] RATE_BAD  = 2'd3;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_SLEEP  = 2'd1,
    ST_SETTLE = 2'd2
  } dspState_t;

  typedef struct packed {
    logic goSleep;
    logic goWake;
    logic settleInc;
    logic fireInt;
  } ctrlStrb_t;
endpackage

// File: rtl/clkslp_datapath.sv
module clkslp_datapath
  import clkslp_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int DELAY_W   = 16,
  parameter int DEF_DELAY = 256,
  parameter int NUM_INT   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic               regFromDsp,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  input  ctrlStrb_t          strb,
  input  logic               dspClkOn,
  output logic               sleepReq,
  output logic               settleDone,
  output logic               hostClkEn,
  output logic [NUM_INT-1:0] wakeInt,
  output logic               dspRstN
);
  localparam int INT_W = (NUM_INT > 1) ? $clog2(NUM_INT) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = {DIV_W{1'b1}};

  logic [1:0]         rateReq, rateAct;
  logic               enReq, enAct;
  logic [DIV_W-1:0]   divCnt;
  logic               tick;
  logic [DELAY_W-1:0] settleDelay, settleCnt;
  logic [INT_W-1:0]   intSel, lineLatch;
  logic [NUM_INT-1:0] intReg;
  logic               rstHold;
  logic               wrHost, wrDsp;

  assign wrHost   = regWe && !regFromDsp;
  assign wrDsp    = regWe && regFromDsp;
  assign sleepReq = wrDsp && (regAddr == ADDR_DSPCMD) && regWdata[0];

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rateReq     <= RATE_DIV2;
      enReq       <= 1'b1;
      settleDelay <= DELAY_W'(DEF_DELAY);
      intSel      <= '0;
    end else begin
      if (wrHost && regAddr == ADDR_RATE && regWdata[1:0] != RATE_BAD)
        rateReq <= regWdata[1:0];
      if (wrHost && regAddr == ADDR_HOSTEN)
        enReq <= regWdata[0];
      if (regWe && regAddr == ADDR_DELAY)
        settleDelay <= regWdata[DELAY_W-1:0];
      if (regWe && regAddr == ADDR_INTSEL)
        intSel <= regWdata[INT_W-1:0];
    end
  end

  // divider: settings move to the active copy only at the period wrap
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt  <= '0;
      rateAct <= RATE_DIV2;
      enAct   <= 1'b1;
    end else begin
      divCnt <= divCnt + 1'b1;
      if (divCnt == DIV_LAST) begin
        rateAct <= rateReq;
        enAct   <= enReq;
      end
    end
  end

  always_comb begin
    case (rateAct)
      RATE_DIV1: tick = 1'b1;
      RATE_DIV2: tick = divCnt[0];
      default:   tick = &divCnt;
    endcase
  end

  assign hostClkEn = enAct && tick;

  // settling / lock-delay counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      settleCnt <= '0;
      lineLatch <= '0;
    end else if (strb.goWake) begin
      settleCnt <= '0;
      lineLatch <= intSel;
    end else if (strb.settleInc) begin
      settleCnt <= settleCnt + 1'b1;
    end
  end

  assign settleDone = ({1'b0, settleCnt} + 1'b1) >= {1'b0, settleDelay};

  // one pulse register per interrupt line
  for (genvar i = 0; i < NUM_INT; i++) begin : g_intLine
    always_ff @(posedge clk) begin
      if (!rstN) intReg[i] <= 1'b0;
      else       intReg[i] <= strb.fireInt && (lineLatch == INT_W'(i));
    end
  end

  assign wakeInt = intReg;

  always_ff @(posedge clk) begin
    if (!rstN) rstHold <= 1'b0;
    else       rstHold <= 1'b1;
  end

  assign dspRstN = rstHold;

  // R3: active rate and enable only change right after a divider wrap
  assert_rate_boundary_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rateAct != $past(rateAct) || enAct != $past(enAct)) |-> $past(divCnt) == DIV_LAST);

  // R9: never more than one interrupt line at a time
  assert_int_onehot_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wakeInt));

  // R8: the interrupt comes strictly after the clock is already back
  assert_int_after_restart_R8: assert property (@(posedge clk) disable iff (!rstN)
    (|wakeInt) |-> (dspClkOn && $past(dspClkOn)));

  // R11: restarting the clock never coincides with reset
  assert_no_reset_on_wake_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dspClkOn) |-> dspRstN);
endmodule

// File: rtl/clkslp_control.sv
module clkslp_control
  import clkslp_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sleepReq,
  input  logic      wakeReq,
  input  logic      settleDone,
  output ctrlStrb_t strb,
  output logic      dspClkOn,
  output logic      pllLock,
  output logic      asleep
);
  dspState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strb      = '0;
    case (state)
      ST_RUN: begin
        if (sleepReq) begin
          strb.goSleep = 1'b1;
          stateNext    = ST_SLEEP;
        end
      end
      ST_SLEEP: begin
        if (wakeReq) begin
          strb.goWake = 1'b1;
          stateNext   = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (settleDone) begin
          strb.fireInt = 1'b1;
          stateNext    = ST_RUN;
        end else begin
          strb.settleInc = 1'b1;
        end
      end
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end

  assign dspClkOn = (state != ST_SLEEP);
  assign pllLock  = (state == ST_RUN);
  assign asleep   = (state == ST_SLEEP);

  // R6: the clock only stops in response to an accepted stop command
  assert_sleep_on_cmd_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dspClkOn) |-> $past(sleepReq));

  // R10: a wake strobe while running leaves the controller running
  assert_wake_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && wakeReq && !sleepReq) |=> state == ST_RUN);
endmodule

// File: rtl/clkslp_top.sv
module clkslp_top
  import clkslp_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int DELAY_W   = 16,
  parameter int DEF_DELAY = 256,
  parameter int NUM_INT   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic               regFromDsp,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  input  logic               mailboxMsg,
  input  logic               timerWake,
  output logic               hostClkEn,
  output logic               dspClkEn,
  output logic               pllLocked,
  output logic [NUM_INT-1:0] wakeInt,
  output logic               dspRstN,
  output logic               dspAsleep
);
  ctrlStrb_t strb;
  logic      sleepReq, settleDone, wakeReq;

  assign wakeReq = mailboxMsg | timerWake;

  clkslp_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sleepReq   (sleepReq),
    .wakeReq    (wakeReq),
    .settleDone (settleDone),
    .strb       (strb),
    .dspClkOn   (dspClkEn),
    .pllLock    (pllLocked),
    .asleep     (dspAsleep)
  );

  clkslp_datapath #(
    .DATA_W    (DATA_W),
    .DELAY_W   (DELAY_W),
    .DEF_DELAY (DEF_DELAY),
    .NUM_INT   (NUM_INT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .regWe      (regWe),
    .regFromDsp (regFromDsp),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .strb       (strb),
    .dspClkOn   (dspClkEn),
    .sleepReq   (sleepReq),
    .settleDone (settleDone),
    .hostClkEn  (hostClkEn),
    .wakeInt    (wakeInt),
    .dspRstN    (dspRstN)
  );
endmodule

// File: tb/tb_clkslp_top.sv
`timescale 1ns/1ps
module tb_clkslp_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic        regFromDsp = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic        mailboxMsg = 1'b0;
  logic        timerWake = 1'b0;
  logic        hostClkEn, dspClkEn, pllLocked, dspRstN, dspAsleep;
  logic [1:0]  wakeInt;

  clkslp_top dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regFromDsp(regFromDsp),
    .regAddr(regAddr), .regWdata(regWdata), .mailboxMsg(mailboxMsg),
    .timerWake(timerWake), .hostClkEn(hostClkEn), .dspClkEn(dspClkEn),
    .pllLocked(pllLocked), .wakeInt(wakeInt), .dspRstN(dspRstN),
    .dspAsleep(dspAsleep)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int intsSeen = 0;
  bit finished = 0;

  typedef struct { int when; int line; } expInt_t;
  expInt_t expQ[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: pops expected interrupts as the design produces them
  always @(negedge clk) begin
    if (rstN && wakeInt != 2'b00) begin
      intsSeen++;
      if (expQ.size() == 0) begin
        chk(0, "R10 unexpected interrupt", int'(wakeInt), 0);
      end else begin
        expInt_t e;
        e = expQ.pop_front();
        chk(cyc == e.when, "R8 interrupt cycle", cyc, e.when);
        chk(wakeInt == (2'b01 << e.line), "R9 interrupt line", int'(wakeInt), 1 << e.line);
        chk(pllLocked == 1'b1, "R8 lock with interrupt", int'(pllLocked), 1);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input bit fromDsp);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d; regFromDsp = fromDsp;
    @(negedge clk);
    regWe = 1'b0; regFromDsp = 1'b0;
  endtask

  task automatic countTicks(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (hostClkEn) cnt++;
    end
  endtask

  task automatic settleWait();
    for (int i = 0; i < 8; i++) @(negedge clk);
  endtask

  // driver: issues a wake strobe and pushes the expected interrupt
  task automatic wake(input bit useMbox, input int delay, input int line);
    expInt_t e;
    int d;
    d = (delay == 0) ? 1 : delay;
    @(negedge clk);
    e.when = cyc + 1 + d;
    e.line = line;
    expQ.push_back(e);
    if (useMbox) mailboxMsg = 1'b1; else timerWake = 1'b1;
    @(negedge clk);
    mailboxMsg = 1'b0; timerWake = 1'b0;
    chk(dspClkEn == 1'b1, "R7 clock back after wake", int'(dspClkEn), 1);
    chk(pllLocked == 1'b0, "R7 lock low while settling", int'(pllLocked), 0);
    chk(dspRstN == 1'b1, "R11 reset untouched on wake", int'(dspRstN), 1);
  endtask

  task automatic sleepCmd();
    wr(3'd2, 16'h0001, 1'b1);
    chk(dspClkEn == 1'b0, "R6 clock stopped", int'(dspClkEn), 1'b0);
    chk(pllLocked == 1'b0, "R6 lock model held", int'(pllLocked), 0);
    chk(dspAsleep == 1'b1, "R6 asleep status", int'(dspAsleep), 1);
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      summary();
    end
  end

  initial begin
    int cnt, prevTick, gapA, gapB, seenBefore;
    waitCycles(3);
    chk(dspRstN == 1'b0, "R11 reset output during reset", int'(dspRstN), 0);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(dspClkEn == 1'b1, "R1 dsp clock on", int'(dspClkEn), 1);
    chk(pllLocked == 1'b1, "R1 locked", int'(pllLocked), 1);
    chk(wakeInt == 2'b00, "R1 no interrupt", int'(wakeInt), 0);
    chk(dspRstN == 1'b1, "R11 reset released", int'(dspRstN), 1);
    countTicks(16, cnt);
    chk(cnt == 8, "R1 default rate div2", cnt, 8);

    // R2 rate select
    wr(3'd0, 16'd2, 1'b0); settleWait(); countTicks(16, cnt);
    chk(cnt == 4, "R2 div4 rate", cnt, 4);
    // R3 spacing at div4
    prevTick = -1; gapA = 0; gapB = 0;
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      if (hostClkEn) begin
        if (prevTick >= 0) begin gapA = gapB; gapB = cyc - prevTick; end
        prevTick = cyc;
      end
    end
    chk(gapA == 4 && gapB == 4, "R3 div4 pulse spacing", gapB, 4);
    wr(3'd0, 16'd0, 1'b0); settleWait(); countTicks(16, cnt);
    chk(cnt == 16, "R2 div1 rate", cnt, 16);
    wr(3'd0, 16'd3, 1'b0); settleWait(); countTicks(16, cnt);
    chk(cnt == 16, "R2 code 3 ignored", cnt, 16);
    wr(3'd0, 16'd2, 1'b1); settleWait(); countTicks(16, cnt);
    chk(cnt == 16, "R5 rate write from dsp ignored", cnt, 16);

    // R4 host gate
    wr(3'd1, 16'd0, 1'b0); settleWait(); countTicks(16, cnt);
    chk(cnt == 0, "R4 host clock gated", cnt, 0);
    wr(3'd1, 16'd1, 1'b1); settleWait(); countTicks(16, cnt);
    chk(cnt == 0, "R5 enable write from dsp ignored", cnt, 0);
    wr(3'd1, 16'd1, 1'b0); settleWait(); countTicks(16, cnt);
    chk(cnt == 16, "R4 host clock restored", cnt, 16);

    // R5 stop command from host ignored
    wr(3'd2, 16'd1, 1'b0);
    chk(dspClkEn == 1'b1, "R5 host stop write ignored", int'(dspClkEn), 1);

    // R10 wake while running
    seenBefore = intsSeen;
    @(negedge clk); mailboxMsg = 1'b1; @(negedge clk); mailboxMsg = 1'b0;
    waitCycles(300);
    chk(intsSeen == seenBefore, "R10 wake while running ignored", intsSeen, seenBefore);

    // default delay 256, line 0, timer wake
    sleepCmd();
    waitCycles(5);
    wake(1'b0, 256, 0);
    waitCycles(260);

    // delay 5, line 1, mailbox wake; R10 second wake while settling
    wr(3'd3, 16'd5, 1'b0);
    wr(3'd4, 16'd1, 1'b0);
    sleepCmd();
    wake(1'b1, 5, 1);
    timerWake = 1'b1; @(negedge clk); timerWake = 1'b0;
    waitCycles(20);

    // corner: delay 0 behaves as 1, then delay 1
    wr(3'd3, 16'd0, 1'b0);
    wr(3'd4, 16'd0, 1'b1);
    sleepCmd();
    wake(1'b0, 0, 0);
    waitCycles(6);
    wr(3'd3, 16'd1, 1'b0);
    sleepCmd();
    wake(1'b1, 1, 0);
    waitCycles(6);
    chk(pllLocked == 1'b1, "R8 lock after settle", int'(pllLocked), 1);
    chk(dspRstN == 1'b1, "R11 reset never pulsed", int'(dspRstN), 1);

    chk(expQ.size() == 0, "R8 all interrupts arrived", expQ.size(), 0);
    chk(intsSeen == 4, "R10 interrupt count", intsSeen, 4);
    summary();
  end
endmodule